// File: doc/BRIEF.md
# Scaled sample to decimal converter

This block accepts a 12-bit unsigned converter sample and turns it into a reading in units of 0.1 mV against a 3.3 V full scale. The sample is first multiplied by 129/16 using only a shift and one addition, which gives a value from 0 up to 33015. That binary value is then turned into five BCD digits for a seven-segment display. The conversion does not use shift-and-correct logic. Instead, a chain of decimal digit counters starts at zero and counts up alongside a plain binary counter until the binary counter reaches the scaled value.

A conversion begins when `start_i` is sampled high while the block is idle. The block ends it with a one-cycle `done_o` pulse. At that same clock edge the finished digits are copied into a shadow register that drives `digits_o`. The display therefore shows the last completed reading at all times, and never shows a partial count. A conversion of scaled value N takes N+1 cycles after the edge that accepts start.

The controller has two states. In `ST_IDLE` it waits for a start request. The transition *accept* (start high in `ST_IDLE`) latches the scaled target, clears both counters and moves to `ST_COUNT`. In `ST_COUNT` the transition *step* (count differs from target) advances both counters and stays in `ST_COUNT`. The transition *finish* (count equals target) loads the shadow register, raises done and returns to `ST_IDLE`.

Top module: `volt_bcd_conv`

## Requirements
- R1: After reset, `digits_o` is all zeros and `done_o` is low.
- R2: The displayed value equals floor(sample × 129 / 16), formed as (sample shifted left by 7, plus sample), then shifted right by 4.
- R3: `digits_o` holds the scaled value as five 4-bit BCD digits, each in the range 0 to 9. The least significant digit is in bits [3:0], and digit k is in bits [4k+3:4k].
- R4: `done_o` is high for exactly one cycle. It is observed N+1 clock cycles after the edge that accepted start, where N is the scaled value.
- R5: A sample of zero completes on the cycle after the accepting edge's successor, with all digits zero.
- R6: A start request made while a conversion is running has no effect. The running conversion finishes with its own sample and its own timing.
- R7: `digits_o` keeps the previous result throughout a conversion, and changes only at the edge that raises `done_o`.
- R8: Carries ripple through all five digits. Full scale (sample 4095) reads 33015, and sample 1241 reads 10005.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| sample_i | input | 12 | Unsigned sample, captured on the accepting edge |
| digits_o | output | 20 | Five packed BCD digits of the last completed result |
| done_o | output | 1 | One-cycle pulse when a new result is shown |

## Verification
The bench builds the block with its default parameters: a 12-bit sample, a multiply shift of 7, a divide shift of 4 and five digits. With these values the full-scale input of 4095 can be reached, along with the longest run of about 33,000 cycles and a carry through all four digit boundaries. Small inputs (0, 1, 2, 16) check exact latency and rounding down. A start request issued partway through a 10005-count conversion checks that it is ignored, and the same run checks that the display holds its previous value.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } vbc_state_e;
endpackage

// File: rtl/vbc_scale.sv
module vbc_scale #(
    parameter int SAMPLE_W  = 12,
    parameter int MUL_SHIFT = 7,
    parameter int DIV_SHIFT = 4,
    localparam int PROD_W   = SAMPLE_W + MUL_SHIFT + 1,
    localparam int SCALE_W  = PROD_W - DIV_SHIFT
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SCALE_W-1:0]  scaled_o
);
    logic [PROD_W-1:0] shifted;
    logic [PROD_W-1:0] widened;
    logic [PROD_W-1:0] product;

    always_comb begin
        shifted  = {1'b0, sample_i, {MUL_SHIFT{1'b0}}};
        widened  = {{(PROD_W-SAMPLE_W){1'b0}}, sample_i};
        product  = shifted + widened;
        scaled_o = product[PROD_W-1:DIV_SHIFT];
    end
endmodule

// File: rtl/vbc_bcd_counter.sv
module vbc_bcd_counter
    import vbc_pkg::*;
#(
    parameter int NUM_DIGITS = 5,
    localparam int BUS_W     = NUM_DIGITS * DIGIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [BUS_W-1:0] count_o
);
    logic [NUM_DIGITS:0] carry;

    assign carry[0] = inc_i;

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        logic [DIGIT_W-1:0] digit_q;
        logic               at_nine;

        assign at_nine      = (digit_q == DIGIT_W'(9));
        assign carry[k+1]   = carry[k] && at_nine;
        assign count_o[k*DIGIT_W +: DIGIT_W] = digit_q;

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                digit_q <= '0;
            end else if (carry[k]) begin
                digit_q <= at_nine ? '0 : digit_q + DIGIT_W'(1);
            end
        end

        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
            digit_q <= DIGIT_W'(9)); // R3
    end
endmodule

// File: rtl/vbc_ctrl.sv
module vbc_ctrl
    import vbc_pkg::*;
#(
    parameter int SCALE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [SCALE_W-1:0] scaled_i,
    output logic               cnt_clr_o,
    output logic               cnt_inc_o,
    output logic               shadow_load_o,
    output logic               done_o
);
    vbc_state_e         state_q;
    vbc_state_e         state_d;
    logic [SCALE_W-1:0] target_q;
    logic [SCALE_W-1:0] bin_cnt_q;
    logic               reached;
    logic               done_q;

    assign reached = (bin_cnt_q == target_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        cnt_clr_o     = 1'b0;
        cnt_inc_o     = 1'b0;
        shadow_load_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    cnt_clr_o = 1'b1;
                    state_d   = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (reached) begin
                    shadow_load_o = 1'b1;
                    state_d       = ST_IDLE;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            target_q  <= '0;
            bin_cnt_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= shadow_load_o;
            if (cnt_clr_o) begin
                target_q  <= scaled_i;
                bin_cnt_q <= '0;
            end else if (cnt_inc_o) begin
                bin_cnt_q <= bin_cnt_q + SCALE_W'(1);
            end
        end
    end

    assign done_o = done_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COUNT) |-> (bin_cnt_q <= target_q)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COUNT && start_i) |=> $stable(target_q)); // R6
    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i && scaled_i == '0) |=> ##1 done_q); // R5
endmodule

// File: rtl/volt_bcd_conv.sv
module volt_bcd_conv
    import vbc_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int MUL_SHIFT  = 7,
    parameter int DIV_SHIFT  = 4,
    parameter int NUM_DIGITS = 5,
    localparam int SCALE_W   = SAMPLE_W + MUL_SHIFT + 1 - DIV_SHIFT,
    localparam int BUS_W     = NUM_DIGITS * DIGIT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [BUS_W-1:0]    digits_o,
    output logic                done_o
);
    logic [SCALE_W-1:0] scaled;
    logic               cnt_clr;
    logic               cnt_inc;
    logic               shadow_load;
    logic [BUS_W-1:0]   bcd_count;
    logic [BUS_W-1:0]   shadow_q;

    vbc_scale #(
        .SAMPLE_W  (SAMPLE_W),
        .MUL_SHIFT (MUL_SHIFT),
        .DIV_SHIFT (DIV_SHIFT)
    ) u_scale (
        .sample_i (sample_i),
        .scaled_o (scaled)
    );

    vbc_ctrl #(
        .SCALE_W (SCALE_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .scaled_i      (scaled),
        .cnt_clr_o     (cnt_clr),
        .cnt_inc_o     (cnt_inc),
        .shadow_load_o (shadow_load),
        .done_o        (done_o)
    );

    vbc_bcd_counter #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_bcd (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .count_o (bcd_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (shadow_load) begin
            shadow_q <= bcd_count;
        end
    end

    assign digits_o = shadow_q;

    AST_DISPLAY_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (done_o || $stable(digits_o))); // R7
endmodule

// File: tb/volt_bcd_conv_bench.sv
`timescale 1ns/1ps
module volt_bcd_conv_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [11:0] sample_i;
    logic [19:0] digits_o;
    logic        done_o;

    int total = 0;
    int failed = 0;
    logic [19:0] last_shown = '0;

    always #5 clk = ~clk;

    volt_bcd_conv u_volt_bcd_conv (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .sample_i (sample_i),
        .digits_o (digits_o),
        .done_o   (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int scale_ref(input int s);
        return (s * 129) / 16;
    endfunction

    function automatic logic [19:0] bcd_ref(input int v);
        logic [19:0] r = '0;
        int p = 1;
        for (int d = 0; d < 5; d++) begin
            r[d*4 +: 4] = 4'((v / p) % 10);
            p = p * 10;
        end
        return r;
    endfunction

    // one conversion; optional second start at cycle late_k with late_sample
    task automatic run_conv(input int s, input string req, input int late_k, input int late_sample);
        int n = scale_ref(s);
        logic [19:0] exp = bcd_ref(n);
        int seen = -1;
        int hold_bad = 0;
        int after_done = 0;
        @(negedge clk);
        sample_i = 12'(s);
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        if (done_o) seen = 0;
        for (int k = 1; k <= n + 3 && k < 40000; k++) begin
            if (k == late_k) begin
                sample_i = 12'(late_sample);
                start_i  = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (done_o && seen < 0) seen = k;
            else if (done_o) after_done++;
            if (seen < 0 && digits_o != last_shown) hold_bad++;
        end
        check(seen == n + 1, {req, " R4 latency"}, seen, n + 1);
        check(digits_o == exp, {req, " R2 R3 digits"}, int'(digits_o), int'(exp));
        check(hold_bad == 0 && after_done == 0, {req, " R7 hold and single pulse"}, hold_bad + after_done, 0);
        last_shown = digits_o;
    endtask

    task automatic test_reset();
        rst = 1'b1; start_i = 1'b0; sample_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(digits_o == '0, "R1 digits", int'(digits_o), 0);
        check(done_o == 1'b0, "R1 done", int'(done_o), 0);
    endtask

    task automatic test_zero();
        run_conv(0, "R5 zero", -1, 0);
    endtask

    task automatic test_small();
        run_conv(1, "R2 sample1", -1, 0);
        run_conv(2, "R2 sample2", -1, 0);
        run_conv(16, "R2 sample16", -1, 0);
        run_conv(0, "R5 zero after nonzero", -1, 0);
    endtask

    task automatic test_cascade();
        run_conv(1241, "R8 carry 10005", -1, 0);
        run_conv(4095, "R8 full scale", -1, 0);
    endtask

    task automatic test_ignore_start();
        run_conv(1241, "R6 late start ignored", 50, 4095);
        check(digits_o == 20'h10005, "R6 result", int'(digits_o), 'h10005);
    endtask

    initial begin
        #1900000;
        failed++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        test_reset();
        test_zero();
        test_small();
        test_cascade();
        test_ignore_start();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule